// File: doc/BRIEF.md
# OTG Line Status Event Tracker

This block keeps the 16-bit OTG line status word for a USB controller. The word is built from bus-detection levels that arrive with strobes. One strobed level reports VBUS valid. A second reports session valid. A third group covers the remaining line bits: power/clock good, VBUS sense, ID status, host disconnect and the two-bit line state. Software reads the word through a small addressed read port, and the data comes back one cycle after the request.

The block raises a single-cycle event toward the interrupt aggregator only when the stored VBUS-valid bit actually flips. A strobe that repeats the current level raises nothing. Session transitions and the other line bits update the word silently. The session-valid and session-end bits are kept as a mutually exclusive pair. After reset the whole word is zero, and a clear ID bit means host mode.

Top module: `otg_line_status`

## Requirements
- R1: After reset the status word reads 0x0000 and the VBUS event output is low.
- R2: On a VBUS strobe, bit 5 of the status word takes the VBUS input level. Without a strobe, bit 5 holds its value whatever the level input does.
- R3: The VBUS event pulses high for exactly one cycle, in the first cycle the new bit 5 is visible, and only when a VBUS strobe changes the stored bit 5. A strobe carrying the current value raises no event.
- R4: On a session strobe with level 1, bit 6 (session valid) is set and bit 7 (session end) is cleared. With level 0, bit 6 is cleared and bit 7 is set. Bits 6 and 7 are never both set.
- R5: A session strobe never raises the VBUS event.
- R6: An auxiliary strobe loads the following inputs, and raises no event:
  - bit 8: power/clock good
  - bit 4: VBUS sense
  - bit 3: ID status
  - bit 2: host disconnect
  - bits 1:0: line state
- R7: A read request at the status address returns the current status word on the read data output one cycle later, with the valid output high. A read at any other address returns zero with valid high.
- R8: Bits 15:9 of the status word always read zero.
- R9: Strobes that arrive in the same cycle all take effect at the same clock edge. The event depends only on the VBUS bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vbus_stb | input | 1 | VBUS level strobe |
| vbus_lvl | input | 1 | VBUS valid level |
| sess_stb | input | 1 | Session level strobe |
| sess_lvl | input | 1 | Session valid level |
| aux_stb | input | 1 | Strobe for the remaining line bits |
| pwr_clk_good | input | 1 | Power/clock good level |
| vbus_sense | input | 1 | VBUS sense level |
| id_level | input | 1 | ID status level (0 = host) |
| host_discon | input | 1 | Host disconnect level |
| line_state | input | 2 | D+/D- line state |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 16 | Read data |
| vbus_evt | output | 1 | Single-cycle VBUS change event |

## Verification
The bench builds the block with its default parameters: a 4-bit read address with the status word at address 3. This lets it sweep all sixteen addresses in a short run, including every address that must read zero. It drives repeated, missing and simultaneous strobes, so that each event is tied to a real change of bit 5 and never to a strobe alone. It also checks the exclusive session pair after both polarities.

// File: rtl/otg_stat_pkg.sv
package otg_stat_pkg;

    localparam int STAT_W     = 16;
    localparam int BIT_LS0    = 0;
    localparam int LS_W       = 2;
    localparam int BIT_HDISC  = 2;
    localparam int BIT_ID     = 3;
    localparam int BIT_VSENSE = 4;
    localparam int BIT_VBUS   = 5;
    localparam int BIT_SVALID = 6;
    localparam int BIT_SEND   = 7;
    localparam int BIT_PCLK   = 8;

    typedef struct packed {
        logic vbus;
        logic evt;
    } vbus_state_t;

    typedef struct packed {
        logic valid;
        logic ended;
    } sess_state_t;

    typedef struct packed {
        logic            pclk;
        logic            vsense;
        logic            id;
        logic            hdisc;
        logic [LS_W-1:0] ls;
    } aux_state_t;

endpackage

// File: rtl/otg_vbus_track.sv
module otg_vbus_track
    import otg_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic lvl_i,
    output logic vbus_o,
    output logic evt_o
);

    vbus_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        if (stb_i) begin
            st_d.vbus = lvl_i;
            st_d.evt  = (lvl_i != st_q.vbus);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vbus_o = st_q.vbus;
    assign evt_o  = st_q.evt;

    AST_EVT_NEEDS_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_o) |-> (vbus_o != $past(vbus_o))); // R3
    AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> ($stable(vbus_o) && !evt_o)); // R2

endmodule

// File: rtl/otg_sess_track.sv
module otg_sess_track
    import otg_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic lvl_i,
    output logic valid_o,
    output logic ended_o
);

    sess_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stb_i) begin
            st_d.valid = lvl_i;
            st_d.ended = ~lvl_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign ended_o = st_q.ended;

    AST_SESS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({valid_o, ended_o})); // R4
    AST_SESS_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i |=> (valid_o != ended_o)); // R4

endmodule

// File: rtl/otg_stat_rdport.sv
module otg_stat_rdport #(
    parameter int                ADDR_W    = 4,
    parameter int                DATA_W    = 16,
    parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [DATA_W-1:0] stat_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = rd_en_i;
        if (rd_en_i) begin
            st_d.data = (rd_addr_i == STAT_ADDR) ? stat_i : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid_o = st_q.valid;
    assign rd_data_o  = st_q.data;

    AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o); // R7
    AST_RD_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (rd_addr_i != STAT_ADDR)) |=> (rd_data_o == '0)); // R7

endmodule

// File: rtl/otg_line_status.sv
module otg_line_status
    import otg_stat_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vbus_stb,
    input  logic              vbus_lvl,
    input  logic              sess_stb,
    input  logic              sess_lvl,
    input  logic              aux_stb,
    input  logic              pwr_clk_good,
    input  logic              vbus_sense,
    input  logic              id_level,
    input  logic              host_discon,
    input  logic [LS_W-1:0]   line_state,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [STAT_W-1:0] rd_data,
    output logic              vbus_evt
);

    logic              vbus_bit;
    logic              sess_valid;
    logic              sess_ended;
    logic [STAT_W-1:0] stat_word;
    aux_state_t        aux_d, aux_q;

    otg_vbus_track u_vbus (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (vbus_stb),
        .lvl_i  (vbus_lvl),
        .vbus_o (vbus_bit),
        .evt_o  (vbus_evt)
    );

    otg_sess_track u_sess (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (sess_stb),
        .lvl_i   (sess_lvl),
        .valid_o (sess_valid),
        .ended_o (sess_ended)
    );

    always_comb begin
        aux_d = aux_q;
        if (aux_stb) begin
            aux_d.pclk   = pwr_clk_good;
            aux_d.vsense = vbus_sense;
            aux_d.id     = id_level;
            aux_d.hdisc  = host_discon;
            aux_d.ls     = line_state;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) aux_q <= '0;
        else        aux_q <= aux_d;
    end

    always_comb begin
        stat_word                     = '0;
        stat_word[BIT_LS0 +: LS_W]    = aux_q.ls;
        stat_word[BIT_HDISC]          = aux_q.hdisc;
        stat_word[BIT_ID]             = aux_q.id;
        stat_word[BIT_VSENSE]         = aux_q.vsense;
        stat_word[BIT_VBUS]           = vbus_bit;
        stat_word[BIT_SVALID]         = sess_valid;
        stat_word[BIT_SEND]           = sess_ended;
        stat_word[BIT_PCLK]           = aux_q.pclk;
    end

    otg_stat_rdport #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (STAT_W),
        .STAT_ADDR (STAT_ADDR)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (rd_en),
        .rd_addr_i  (rd_addr),
        .stat_i     (stat_word),
        .rd_valid_o (rd_valid),
        .rd_data_o  (rd_data)
    );

    AST_SESS_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (sess_stb && !vbus_stb) |=> !vbus_evt); // R5
    AST_AUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_stb |=> $stable(aux_q)); // R6
    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[STAT_W-1:BIT_PCLK+1] == '0)); // R8

endmodule

// File: tb/tb_otg_line_status.sv
module tb_otg_line_status;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vbus_stb = 0, vbus_lvl = 0, sess_stb = 0, sess_lvl = 0, aux_stb = 0;
    logic        pwr_clk_good = 0, vbus_sense = 0, id_level = 0, host_discon = 0;
    logic [1:0]  line_state = 2'b00;
    logic        rd_en = 0;
    logic [3:0]  rd_addr = 4'd0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        vbus_evt;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] exp_stat = 16'h0000;

    always #2 clk = ~clk;

    otg_line_status dut (
        .clk(clk), .rst_n(rst_n),
        .vbus_stb(vbus_stb), .vbus_lvl(vbus_lvl),
        .sess_stb(sess_stb), .sess_lvl(sess_lvl),
        .aux_stb(aux_stb), .pwr_clk_good(pwr_clk_good), .vbus_sense(vbus_sense),
        .id_level(id_level), .host_discon(host_discon), .line_state(line_state),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .vbus_evt(vbus_evt)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_at(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = a;
        @(posedge clk);
        #1;
        check("R7 valid", {15'd0, rd_valid}, 16'd1);
        d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic check_stat(input string tag);
        logic [15:0] d;
        read_at(4'd3, d);
        check(tag, d, exp_stat);
        check("R8 high bits", {7'd0, d[15:9]}, 16'd0);
    endtask

    task automatic t_reset;
        check("R1 evt", {15'd0, vbus_evt}, 16'd0);
        check_stat("R1 status");
    endtask

    task automatic t_vbus(input logic lvl, input logic exp_evt, input string tag);
        @(negedge clk);
        vbus_lvl = lvl;
        vbus_stb = 1'b1;
        @(posedge clk);
        #1;
        check({tag, " R3 evt"}, {15'd0, vbus_evt}, {15'd0, exp_evt});
        @(negedge clk);
        vbus_stb = 1'b0;
        @(posedge clk);
        #1;
        check({tag, " R3 one cycle"}, {15'd0, vbus_evt}, 16'd0);
        exp_stat[5] = lvl;
        check_stat({tag, " R2 status"});
    endtask

    task automatic t_no_strobe;
        @(negedge clk);
        vbus_lvl = ~exp_stat[5];
        repeat (3) begin
            @(posedge clk);
            #1;
            check("R2 no strobe evt", {15'd0, vbus_evt}, 16'd0);
        end
        check_stat("R2 no strobe hold");
    endtask

    task automatic t_sess(input logic lvl, input string tag);
        @(negedge clk);
        sess_lvl = lvl;
        sess_stb = 1'b1;
        @(posedge clk);
        #1;
        check({tag, " R5 no evt"}, {15'd0, vbus_evt}, 16'd0);
        @(negedge clk);
        sess_stb = 1'b0;
        exp_stat[6] = lvl;
        exp_stat[7] = ~lvl;
        check_stat({tag, " R4 status"});
    endtask

    task automatic t_aux;
        @(negedge clk);
        pwr_clk_good = 1; vbus_sense = 1; id_level = 1; host_discon = 0; line_state = 2'b10;
        aux_stb = 1'b1;
        @(posedge clk);
        #1;
        check("R6 no evt", {15'd0, vbus_evt}, 16'd0);
        @(negedge clk);
        aux_stb = 1'b0;
        pwr_clk_good = 0; vbus_sense = 0; id_level = 0; host_discon = 1; line_state = 2'b01;
        exp_stat[8] = 1; exp_stat[4] = 1; exp_stat[3] = 1; exp_stat[2] = 0; exp_stat[1:0] = 2'b10;
        check_stat("R6 status");
    endtask

    task automatic t_simul;
        @(negedge clk);
        vbus_lvl = 1; vbus_stb = 1; sess_lvl = 1; sess_stb = 1;
        @(posedge clk);
        #1;
        check("R9 evt", {15'd0, vbus_evt}, 16'd1);
        @(negedge clk);
        vbus_stb = 0; sess_stb = 0;
        exp_stat[5] = 1; exp_stat[6] = 1; exp_stat[7] = 0;
        check_stat("R9 status");
    endtask

    task automatic t_sweep;
        logic [15:0] d;
        for (int a = 0; a < 16; a++) begin
            read_at(4'(a), d);
            check("R7 sweep", d, (a == 3) ? exp_stat : 16'h0000);
        end
    endtask

    initial begin
        #(4 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_vbus(1'b1, 1'b1, "rise");
        t_vbus(1'b1, 1'b0, "repeat");
        t_vbus(1'b0, 1'b1, "fall");
        t_no_strobe();
        t_sess(1'b1, "sess on");
        t_sess(1'b0, "sess off");
        t_aux();
        t_simul();
        t_sweep();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule